// File: doc/BRIEF.md
# Triggered DAC Data-Path Controller

This block is the digital front end of a single 12-bit digital-to-analog channel. A simple register bus loads a holding value through any of three write formats (12-bit right-aligned, 12-bit left-aligned, 8-bit right-aligned). All three formats fold into one 12-bit holding register. The block then moves that value into the output code that drives the converter. The move happens either on the write itself or when a selected trigger event arrives.

The trigger sources are four timer event lines, one external line and a software bit. A hardware trigger can also raise a DMA request. If another hardware trigger comes before that request is acknowledged, the block records a sticky underrun flag. That flag, together with an enable bit, drives an interrupt line. The converter, its output amplifier and the DMA engine sit outside the block; the block only drives the code, the enable and buffer-disable levels, the request and the interrupt.

Top module: `trig_dac_front`

## Requirements
- R1: After reset, the output code, the holding value, the control word, the status word, the DMA request and the interrupt are all zero.
- R2: A write to 0x08 stores write bits 11:0. A write to 0x0C stores write bits 15:4. A write to 0x10 stores write bits 7:0 as the upper eight bits with the low four bits zero. All three update the same holding value, which reads back at 0x08.
- R3: With trigger enable (control bit 2) clear, a holding write sets the output code on the same clock edge that accepts the write. The output code reads back at 0x2C, and writes to 0x2C have no effect.
- R4: With trigger enable set, a holding write leaves the output code unchanged. Trigger select (control bits 5:3) chooses the source: 0 to 3 pick timer line 0 to 3, 4 picks the external line, 7 picks the software bit, and 5 and 6 pick nothing. Events from sources that are not selected cause no transfer.
- R5: A hardware line passes through two synchronizer flops and a rising-edge detector. Each rising edge makes exactly one transfer, and a line held high does not repeat it. The output code changes on the fourth clock edge after the line first goes high before an edge.
- R6: Writing 1 to bit 0 of 0x04 sets the software trigger bit. When software is selected, the bit clears on the next edge and the output code updates one edge later. The bit reads back at 0x04 bit 0.
- R7: With DMA enable (control bit 12) set, a selected hardware trigger raises the DMA request. The request stays high until an acknowledge is sampled. A software trigger never raises it.
- R8: A selected hardware trigger that arrives while the request is still pending and unacknowledged sets the underrun flag (status 0x34 bit 13). The flag stays set until a write of 1 to that bit clears it.
- R9: The interrupt is high exactly when the underrun flag and the underrun interrupt enable (control bit 13) are both set.
- R10: Control bit 0 is the channel enable and bit 1 is the buffer disable, and both drive output pins. While the channel enable is set, writes cannot change control bits 5:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Bus write strobe |
| wrAddr | input | 6 | Bus write byte address |
| wrData | input | 32 | Bus write data |
| rdAddr | input | 6 | Bus read byte address |
| rdData | output | 32 | Bus read data (combinational) |
| timTrig | input | 4 | Timer trigger event lines |
| extTrig | input | 1 | External trigger line |
| dmaAck | input | 1 | DMA acknowledge |
| dmaReq | output | 1 | DMA request |
| irq | output | 1 | Underrun interrupt |
| chanOn | output | 1 | Channel enable level to converter |
| bufOff | output | 1 | Output buffer disable level |
| dacCode | output | 12 | Output code to converter |

## Verification
The holding path is driven with bit patterns whose nibbles differ, through each of the three formats. A wrong slice or a wrong shift therefore gives a different code. Every trigger source is pulsed in turn while only one is selected, so a wrong select decode moves the output on the wrong line. The output is sampled one edge before and one edge on the expected transfer, which catches a missing or extra pipeline stage. A line held high across a later holding write shows whether a level is being mistaken for an edge. Back-to-back external pulses with and without an acknowledge separate a real underrun from a normal re-request.

// File: rtl/dac_front_pkg.sv
package dac_front_pkg;
  localparam int ADDR_W = 6;
  localparam int BUS_W  = 32;
  localparam int SEL_W  = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 6'h00;
  localparam logic [ADDR_W-1:0] A_SOFT  = 6'h04;
  localparam logic [ADDR_W-1:0] A_R12   = 6'h08;
  localparam logic [ADDR_W-1:0] A_L12   = 6'h0C;
  localparam logic [ADDR_W-1:0] A_R8    = 6'h10;
  localparam logic [ADDR_W-1:0] A_OUT   = 6'h2C;
  localparam logic [ADDR_W-1:0] A_STAT  = 6'h34;

  localparam int BIT_DMA_EN = 12;
  localparam int BIT_UDR    = 13;
  localparam logic [SEL_W-1:0] SEL_SOFT = 3'd7;

  typedef enum logic [1:0] {
    FMT_R12 = 2'd0,
    FMT_L12 = 2'd1,
    FMT_R8  = 2'd2
  } holdFmt_e;

  typedef struct packed {
    logic         holdWr;
    holdFmt_e     fmt;
    logic [15:0]  data;
    logic         loadDirect;
    logic         loadTrig;
  } pathStrobe_t;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic rise
);
  logic [STAGES-1:0] syncQ;
  logic              lastQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '0;
      lastQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[STAGES-2:0], lineIn};
      lastQ <= syncQ[STAGES-1];
    end
  end

  assign rise = syncQ[STAGES-1] & ~lastQ;
endmodule

// File: rtl/dac_ctrl.sv
module dac_ctrl
  import dac_front_pkg::*;
#(
  parameter int N_TIM  = 4,
  parameter int DAC_W  = 12,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BUS_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [BUS_W-1:0]  rdData,
  input  logic [N_TIM-1:0]  timTrig,
  input  logic              extTrig,
  input  logic              dmaAck,
  input  logic [DAC_W-1:0]  holdVal,
  input  logic [DAC_W-1:0]  outVal,
  output pathStrobe_t       stb,
  output logic              dmaReq,
  output logic              irq,
  output logic              chanOn,
  output logic              bufOff
);
  localparam int N_HW = N_TIM + 1;

  logic             trigOn;
  logic [SEL_W-1:0] trigSel;
  logic             dmaOn;
  logic             udrIe;
  logic             swBit;
  logic             udrFlag;
  logic             firePend;
  logic [N_HW-1:0]  hwLines;
  logic [N_HW-1:0]  hwRise;
  logic             hwHit;
  logic             swHit;

  assign hwLines = {extTrig, timTrig};

  for (genvar i = 0; i < N_HW; i++) begin : gSync
    edge_sync #(.STAGES(STAGES)) uSync (
      .clk(clk), .rstN(rstN), .lineIn(hwLines[i]), .rise(hwRise[i])
    );
  end

  always_comb begin
    hwHit = 1'b0;
    if (trigOn && int'(trigSel) < N_HW) hwHit = hwRise[trigSel];
  end
  assign swHit = trigOn && (trigSel == SEL_SOFT) && swBit;

  wire wrCtrl = wrEn && (wrAddr == A_CTRL);
  wire wrSoft = wrEn && (wrAddr == A_SOFT);
  wire wrStat = wrEn && (wrAddr == A_STAT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanOn  <= 1'b0;
      bufOff  <= 1'b0;
      trigOn  <= 1'b0;
      trigSel <= '0;
      dmaOn   <= 1'b0;
      udrIe   <= 1'b0;
    end else if (wrCtrl) begin
      chanOn <= wrData[0];
      bufOff <= wrData[1];
      dmaOn  <= wrData[BIT_DMA_EN];
      udrIe  <= wrData[BIT_UDR];
      if (!chanOn) begin
        trigOn  <= wrData[2];
        trigSel <= wrData[5:3];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      swBit    <= 1'b0;
      firePend <= 1'b0;
    end else begin
      firePend <= hwHit | swHit;
      if (wrSoft && wrData[0]) swBit <= 1'b1;
      else if (swHit)          swBit <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dmaReq  <= 1'b0;
      udrFlag <= 1'b0;
    end else begin
      if (hwHit && dmaOn) dmaReq <= 1'b1;
      else if (dmaAck)    dmaReq <= 1'b0;
      if (hwHit && dmaOn && dmaReq && !dmaAck) udrFlag <= 1'b1;
      else if (wrStat && wrData[BIT_UDR])      udrFlag <= 1'b0;
    end
  end

  assign irq = udrFlag & udrIe;

  wire holdSel = wrEn && (wrAddr == A_R12 || wrAddr == A_L12 || wrAddr == A_R8);
  always_comb begin
    stb.holdWr     = holdSel;
    stb.fmt        = (wrAddr == A_L12) ? FMT_L12 : (wrAddr == A_R8) ? FMT_R8 : FMT_R12;
    stb.data       = wrData[15:0];
    stb.loadDirect = holdSel && !trigOn;
    stb.loadTrig   = firePend;
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      A_CTRL: begin
        rdData[0] = chanOn;
        rdData[1] = bufOff;
        rdData[2] = trigOn;
        rdData[5:3] = trigSel;
        rdData[BIT_DMA_EN] = dmaOn;
        rdData[BIT_UDR] = udrIe;
      end
      A_SOFT: rdData[0] = swBit;
      A_R12:  rdData[DAC_W-1:0] = holdVal;
      A_L12:  rdData[15:16-DAC_W] = holdVal;
      A_R8:   rdData[7:0] = holdVal[DAC_W-1:DAC_W-8];
      A_OUT:  rdData[DAC_W-1:0] = outVal;
      A_STAT: rdData[BIT_UDR] = udrFlag;
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/dac_path.sv
module dac_path
  import dac_front_pkg::*;
#(
  parameter int DAC_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathStrobe_t       stb,
  output logic [DAC_W-1:0]  holdVal,
  output logic [DAC_W-1:0]  outVal
);
  localparam int PAD8 = DAC_W - 8;
  logic [DAC_W-1:0] nextHold;

  always_comb begin
    case (stb.fmt)
      FMT_L12: nextHold = stb.data[15:16-DAC_W];
      FMT_R8:  nextHold = {stb.data[7:0], {PAD8{1'b0}}};
      default: nextHold = stb.data[DAC_W-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdVal <= '0;
      outVal  <= '0;
    end else begin
      if (stb.holdWr) holdVal <= nextHold;
      if (stb.loadDirect)    outVal <= nextHold;
      else if (stb.loadTrig) outVal <= holdVal;
    end
  end
endmodule

// File: rtl/trig_dac_front.sv
module trig_dac_front
  import dac_front_pkg::*;
#(
  parameter int N_TIM  = 4,
  parameter int DAC_W  = 12,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BUS_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [BUS_W-1:0]  rdData,
  input  logic [N_TIM-1:0]  timTrig,
  input  logic              extTrig,
  input  logic              dmaAck,
  output logic              dmaReq,
  output logic              irq,
  output logic              chanOn,
  output logic              bufOff,
  output logic [DAC_W-1:0]  dacCode
);
  pathStrobe_t      pathStb;
  logic [DAC_W-1:0] holdVal;

  dac_ctrl #(.N_TIM(N_TIM), .DAC_W(DAC_W), .STAGES(STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .timTrig(timTrig), .extTrig(extTrig),
    .dmaAck(dmaAck), .holdVal(holdVal), .outVal(dacCode), .stb(pathStb),
    .dmaReq(dmaReq), .irq(irq), .chanOn(chanOn), .bufOff(bufOff)
  );

  dac_path #(.DAC_W(DAC_W)) uPath (
    .clk(clk), .rstN(rstN), .stb(pathStb), .holdVal(holdVal), .outVal(dacCode)
  );
endmodule

// File: rtl/dac_front_chk.sv
module dac_front_chk
  import dac_front_pkg::*;
#(
  parameter int DAC_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [BUS_W-1:0]  wrData,
  input logic              dmaAck,
  input logic              dmaReq,
  input logic              chanOn,
  input logic [DAC_W-1:0]  dacCode,
  input pathStrobe_t       pathStb,
  input logic              swBit,
  input logic              trigOn,
  input logic [SEL_W-1:0]  trigSel,
  input logic              dmaOn,
  input logic              udrFlag
);
  // R3/R4: the code moves only after a direct or trigger load strobe
  a_r3_code_holds: assert property (@(posedge clk) disable iff (!rstN)
    !$past(pathStb.loadDirect || pathStb.loadTrig) |-> $stable(dacCode));

  // R10: trigger fields frozen while the channel is enabled
  a_r10_sel_locked: assert property (@(posedge clk) disable iff (!rstN)
    $past(chanOn) |-> (trigSel == $past(trigSel) && trigOn == $past(trigOn)));

  // R6: a software bit that fires clears on the next edge
  a_r6_soft_clears: assert property (@(posedge clk) disable iff (!rstN)
    (swBit && trigOn && trigSel == SEL_SOFT && !(wrEn && wrAddr == A_SOFT)) |=> !swBit);

  // R7: a new request needs DMA enabled
  a_r7_req_needs_en: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dmaReq) |-> $past(dmaOn));

  // R8: underrun flag is sticky until a clearing write
  a_r8_udr_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ($past(udrFlag) && !$past(wrEn && wrAddr == A_STAT && wrData[BIT_UDR])) |-> udrFlag);
endmodule

bind trig_dac_front dac_front_chk #(.DAC_W(DAC_W)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .dmaAck(dmaAck), .dmaReq(dmaReq), .chanOn(chanOn), .dacCode(dacCode),
  .pathStb(pathStb), .swBit(uCtrl.swBit), .trigOn(uCtrl.trigOn),
  .trigSel(uCtrl.trigSel), .dmaOn(uCtrl.dmaOn), .udrFlag(uCtrl.udrFlag)
);

// File: tb/trig_dac_front_test.sv
`timescale 1ns/100ps
module trig_dac_front_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [5:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [5:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic [3:0]  timTrig = '0;
  logic        extTrig = 1'b0;
  logic        dmaAck = 1'b0;
  logic        dmaReq, irq, chanOn, bufOff;
  logic [11:0] dacCode;
  int nRun = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  trig_dac_front uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .timTrig(timTrig), .extTrig(extTrig),
    .dmaAck(dmaAck), .dmaReq(dmaReq), .irq(irq), .chanOn(chanOn),
    .bufOff(bufOff), .dacCode(dacCode)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRd(input logic [5:0] a, output logic [31:0] v);
    rdAddr = a;
    #0.1;
    v = rdData;
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] ctl(input bit on, input bit bOff, input bit tOn,
                                      input int sel, input bit dma, input bit ie);
    return {18'd0, ie, dma, 6'd0, sel[2:0], tOn, bOff, on};
  endfunction

  task automatic t_reset;
    logic [31:0] v;
    busRd(6'h00, v); check("R1 ctrl", v, 0);
    busRd(6'h34, v); check("R1 status", v, 0);
    busRd(6'h08, v); check("R1 hold", v, 0);
    check("R1 code", dacCode, 0);
    check("R1 dmaReq", dmaReq, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_formats;
    logic [31:0] v;
    busWr(6'h00, ctl(0, 0, 0, 0, 0, 0));
    busWr(6'h08, 32'hFFFF_A5C3);
    check("R2 r12 code", dacCode, 12'h5C3);
    busRd(6'h08, v); check("R2 r12 hold", v, 32'h5C3);
    busWr(6'h0C, 32'h0000_9E7B);
    check("R2 l12 code", dacCode, 12'h9E7);
    busRd(6'h08, v); check("R2 l12 hold", v, 32'h9E7);
    busWr(6'h10, 32'h0000_F16D);
    check("R2 r8 code", dacCode, 12'h6D0);
    busRd(6'h08, v); check("R2 r8 hold", v, 32'h6D0);
    busWr(6'h2C, 32'h0000_0123);
    busRd(6'h2C, v); check("R3 out write ignored", v, 32'h6D0);
    check("R3 code after out write", dacCode, 12'h6D0);
  endtask

  task automatic t_hw_sources;
    for (int s = 0; s < 5; s++) begin
      logic [11:0] val;
      val = 12'h111 * (s + 1);
      busWr(6'h00, ctl(0, 0, 1, s, 0, 0));
      busWr(6'h08, {20'd0, val});
      check("R4 held write no transfer", dacCode, 12'h6D0 + 0);
      // unselected lines pulsed
      @(negedge clk);
      timTrig = (s < 4) ? ~(4'b1 << s) : 4'hF;
      extTrig = (s == 4) ? 1'b0 : 1'b1;
      waitEdges(1); timTrig = '0; extTrig = 1'b0;
      waitEdges(5);
      check("R4 unselected ignored", dacCode, 12'h6D0);
      // selected line rises and is held
      if (s < 4) timTrig[s] = 1'b1; else extTrig = 1'b1;
      waitEdges(3);
      check("R5 not before 4th edge", dacCode, 12'h6D0);
      waitEdges(1);
      check("R5 transfer on 4th edge", dacCode, val);
      busWr(6'h08, 32'h0000_06D0);
      waitEdges(6);
      check("R5 held line single transfer", dacCode, val);
      timTrig = '0; extTrig = 1'b0;
      busWr(6'h00, ctl(0, 0, 0, 0, 0, 0));
      busWr(6'h08, 32'h0000_06D0);
      waitEdges(3);
    end
  endtask

  task automatic t_soft;
    logic [31:0] v;
    busWr(6'h00, ctl(0, 0, 1, 7, 1, 0));
    busWr(6'h08, 32'h0000_0ABC);
    busWr(6'h04, 32'h1);
    check("R6 not yet", dacCode, 12'h6D0);
    waitEdges(1);
    busRd(6'h04, v); check("R6 self clear", v, 0);
    check("R6 still old", dacCode, 12'h6D0);
    waitEdges(1);
    check("R6 transfer", dacCode, 12'hABC);
    check("R7 soft no dma", dmaReq, 0);
    busWr(6'h00, ctl(0, 0, 1, 6, 0, 0));
    busWr(6'h04, 32'h1);
    busWr(6'h08, 32'h0000_0321);
    waitEdges(4);
    check("R4 sel 6 no source", dacCode, 12'hABC);
    busRd(6'h04, v); check("R6 bit waits when unselected", v, 1);
  endtask

  task automatic pulseExt;
    @(negedge clk); extTrig = 1'b1;
    @(negedge clk); extTrig = 1'b0;
  endtask

  task automatic t_dma;
    logic [31:0] v;
    busWr(6'h00, ctl(0, 0, 1, 4, 0, 0));
    pulseExt(); waitEdges(5);
    check("R7 no req when disabled", dmaReq, 0);
    busWr(6'h00, ctl(0, 0, 1, 4, 1, 0));
    pulseExt(); waitEdges(4);
    check("R7 req raised", dmaReq, 1);
    waitEdges(3);
    check("R7 req held", dmaReq, 1);
    @(negedge clk); dmaAck = 1'b1;
    @(negedge clk); dmaAck = 1'b0;
    check("R7 req cleared", dmaReq, 0);
    busRd(6'h34, v); check("R8 no underrun after ack", v, 0);
    pulseExt(); waitEdges(5);
    pulseExt(); waitEdges(5);
    busRd(6'h34, v); check("R8 underrun set", v, 32'h2000);
    check("R9 irq masked", irq, 0);
    busWr(6'h00, ctl(0, 0, 1, 4, 1, 1));
    check("R9 irq raised", irq, 1);
    busWr(6'h34, 32'h0);
    busRd(6'h34, v); check("R8 zero write keeps flag", v, 32'h2000);
    busWr(6'h34, 32'h2000);
    busRd(6'h34, v); check("R8 flag cleared", v, 0);
    check("R9 irq cleared", irq, 0);
    @(negedge clk); dmaAck = 1'b1;
    @(negedge clk); dmaAck = 1'b0;
  endtask

  task automatic t_lock;
    logic [31:0] v;
    busWr(6'h00, ctl(1, 0, 1, 0, 0, 0));
    check("R10 enable pin", chanOn, 1);
    busWr(6'h00, ctl(1, 1, 0, 4, 0, 0));
    busRd(6'h00, v); check("R10 fields locked", v, ctl(1, 1, 1, 0, 0, 0));
    check("R10 buffer pin", bufOff, 1);
    busWr(6'h00, ctl(0, 0, 1, 0, 0, 0));
    busWr(6'h00, ctl(0, 0, 1, 3, 0, 0));
    busRd(6'h00, v); check("R10 unlocked", v, ctl(0, 0, 1, 3, 0, 0));
  endtask

  initial begin
    bit timedOut = 0;
    waitEdges(3);
    rstN = 1'b1;
    fork
      begin
        t_reset();
        t_formats();
        t_hw_sources();
        t_soft();
        t_dma();
        t_lock();
      end
      begin
        repeat (100000) @(posedge clk);
        timedOut = 1;
      end
    join_any
    disable fork;
    if (timedOut) check("watchdog", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule